// File: doc/BRIEF.md
# Host Command to Register Bus Bridge

This block sits between a host byte link and the master of a shared multi-drop register bus. It reads a compact command grammar from the incoming byte stream: a single command letter, then an inline device address byte, a register byte and a byte count. For writes, the data bytes follow. A decoded command becomes one transaction request on the bus side. The request carries the device address, the register, the count and the direction.

Write payload bytes are passed through a registered stream stage to the bus master. For reads, the bytes that the bus master returns are passed through a second registered stage to the host. The parser stops taking host bytes while a transaction is outstanding, so one command is in flight at a time. The UART framing and the bus timing belong to neighbouring blocks.

Top module: `cmd_bus_bridge`

## Requirements
- R1: After a synchronous reset the bridge is idle. `host_in_ready` is 1, and `req_valid`, `wr_valid`, `host_out_valid` and `err_addr` are 0.
- R2: A first byte other than 0x72 ('r', read) or 0x77 ('w', write) is consumed and discarded. It raises no request, and the next byte is again treated as a command letter.
- R3: The read sequence is 0x72, device, register, count, with count nonzero and device at most 0x7F. It raises one request with `req_read`=1 and the captured device, register and count.
- R4: The write sequence is 0x77, device, register, count, followed by count value bytes. It raises one request with `req_read`=0. The value bytes then appear on the write stream in arrival order, exactly count of them.
- R5: A count byte of zero ends the command. No request is raised, no payload is expected, and the next byte is a command letter.
- R6: A device byte above 0x7F makes `err_addr` high for exactly one cycle. No request is raised. The rest of that command is consumed without effect: register and count, and for a write also count value bytes.
- R7: For a read, exactly count bytes taken from the bus read stream reach the host stream, in order. `bus_rd_ready` is 0 outside a read.
- R8: `host_in_ready` is 0 while a request is pending, while read data is being forwarded, and after the payload until `txn_done` has arrived and both output stages are empty.
- R9: While `req_valid` is 1 and `req_ready` is 0, the request stays valid and its fields do not change.
- R10: A stalled output stream holds its data. If `wr_valid` (or `host_out_valid`) is 1 without ready, it stays 1 with the same data in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_in_data | input | 8 | Command byte from host |
| host_in_valid | input | 1 | Host byte valid |
| host_in_ready | output | 1 | Bridge accepts host byte |
| req_valid | output | 1 | Transaction request valid |
| req_ready | input | 1 | Bus master accepts request |
| req_read | output | 1 | 1 = read, 0 = write |
| req_dev | output | 7 | Device address |
| req_reg | output | 8 | Register index |
| req_count | output | 8 | Number of data bytes |
| wr_data | output | 8 | Write payload byte |
| wr_valid | output | 1 | Write payload valid |
| wr_ready | input | 1 | Bus master takes payload byte |
| bus_rd_data | input | 8 | Byte read from device |
| bus_rd_valid | input | 1 | Read byte valid |
| bus_rd_ready | output | 1 | Bridge takes read byte |
| host_out_data | output | 8 | Read byte to host |
| host_out_valid | output | 1 | Host output valid |
| host_out_ready | input | 1 | Host takes output byte |
| txn_done | input | 1 | Bus master pulse: transaction finished |
| err_addr | output | 1 | One-cycle pulse: device address out of range |

## Verification
The assertions check the handshake properties on every cycle: the reset state, request and stream stability under stall, the one-cycle shape of the error pulse, that the host input is closed while a request is pending, and that no bus read is taken outside a read. Other properties depend on the content of whole commands, and only the bench scenarios can show them. These are the discarding of stray letters, zero-count commands, the skipping of a bad-address write payload, and exact byte counts and ordering. The bench checks them with a scoreboard fed by a random bus master model.

// File: rtl/cbb_pkg.sv
package cbb_pkg;
  localparam logic [7:0] CMD_RD = 8'h72;
  localparam logic [7:0] CMD_WR = 8'h77;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DEV,
    S_REG,
    S_CNT,
    S_ISSUE,
    S_WPAY,
    S_RPAY,
    S_DRAIN,
    S_WAIT
  } parse_state_t;
endpackage

// File: rtl/stream_stage.sv
module stream_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/cmd_parse_fsm.sv
module cmd_parse_fsm
  import cbb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_read,
  output logic [ADDR_W-1:0] req_dev,
  output logic [DATA_W-1:0] req_reg,
  output logic [CNT_W-1:0]  req_count,
  output logic              wr_in_valid,
  input  logic              wr_in_ready,
  input  logic              bus_rd_valid,
  output logic              bus_rd_ready,
  output logic              rd_in_valid,
  input  logic              rd_in_ready,
  input  logic              wr_busy,
  input  logic              rd_busy,
  input  logic              txn_done,
  output logic              err_addr
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  parse_state_t state;
  logic [CNT_W-1:0] left;
  logic is_read, bad_dev, done_seen;
  logic in_fire, rd_fire, dev_oob;

  assign dev_oob = |in_data[DATA_W-1:ADDR_W];

  always_comb begin
    case (state)
      S_ISSUE, S_RPAY, S_WAIT: in_ready = 1'b0;
      S_WPAY:                  in_ready = wr_in_ready;
      default:                 in_ready = 1'b1;
    endcase
  end

  assign in_fire      = in_valid && in_ready;
  assign req_valid    = (state == S_ISSUE);
  assign wr_in_valid  = (state == S_WPAY) && in_valid;
  assign rd_in_valid  = (state == S_RPAY) && bus_rd_valid;
  assign bus_rd_ready = (state == S_RPAY) && rd_in_ready;
  assign rd_fire      = bus_rd_valid && bus_rd_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      left      <= '0;
      is_read   <= 1'b0;
      bad_dev   <= 1'b0;
      done_seen <= 1'b0;
      err_addr  <= 1'b0;
      req_read  <= 1'b0;
      req_dev   <= '0;
      req_reg   <= '0;
      req_count <= '0;
    end else begin
      err_addr <= 1'b0;
      if (txn_done && (state == S_WPAY || state == S_RPAY || state == S_WAIT))
        done_seen <= 1'b1;
      case (state)
        S_IDLE: begin
          done_seen <= 1'b0;
          if (in_fire && (in_data[7:0] == CMD_RD || in_data[7:0] == CMD_WR)) begin
            is_read <= (in_data[7:0] == CMD_RD);
            state   <= S_DEV;
          end
        end
        S_DEV: if (in_fire) begin
          bad_dev  <= dev_oob;
          err_addr <= dev_oob;
          req_dev  <= in_data[ADDR_W-1:0];
          state    <= S_REG;
        end
        S_REG: if (in_fire) begin
          req_reg <= in_data;
          state   <= S_CNT;
        end
        S_CNT: if (in_fire) begin
          req_count <= in_data[CNT_W-1:0];
          left      <= in_data[CNT_W-1:0];
          req_read  <= is_read;
          if (in_data[CNT_W-1:0] == '0) state <= S_IDLE;
          else if (bad_dev)             state <= is_read ? S_IDLE : S_DRAIN;
          else                          state <= S_ISSUE;
        end
        S_ISSUE: if (req_ready) state <= is_read ? S_RPAY : S_WPAY;
        S_WPAY: if (in_fire) begin
          left <= left - ONE;
          if (left == ONE) state <= S_WAIT;
        end
        S_DRAIN: if (in_fire) begin
          left <= left - ONE;
          if (left == ONE) state <= S_IDLE;
        end
        S_RPAY: if (rd_fire) begin
          left <= left - ONE;
          if (left == ONE) state <= S_WAIT;
        end
        S_WAIT: if ((done_seen || txn_done) && !wr_busy && !rd_busy) begin
          done_seen <= 1'b0;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmd_bus_bridge.sv
module cmd_bus_bridge #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] host_in_data,
  input  logic              host_in_valid,
  output logic              host_in_ready,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_read,
  output logic [ADDR_W-1:0] req_dev,
  output logic [DATA_W-1:0] req_reg,
  output logic [CNT_W-1:0]  req_count,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  input  logic [DATA_W-1:0] bus_rd_data,
  input  logic              bus_rd_valid,
  output logic              bus_rd_ready,
  output logic [DATA_W-1:0] host_out_data,
  output logic              host_out_valid,
  input  logic              host_out_ready,
  input  logic              txn_done,
  output logic              err_addr
);
  logic wr_in_valid, wr_in_ready, rd_in_valid, rd_in_ready;

  cmd_parse_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst),
    .in_valid(host_in_valid), .in_data(host_in_data), .in_ready(host_in_ready),
    .req_valid(req_valid), .req_ready(req_ready), .req_read(req_read),
    .req_dev(req_dev), .req_reg(req_reg), .req_count(req_count),
    .wr_in_valid(wr_in_valid), .wr_in_ready(wr_in_ready),
    .bus_rd_valid(bus_rd_valid), .bus_rd_ready(bus_rd_ready),
    .rd_in_valid(rd_in_valid), .rd_in_ready(rd_in_ready),
    .wr_busy(wr_valid), .rd_busy(host_out_valid),
    .txn_done(txn_done), .err_addr(err_addr)
  );

  stream_stage #(.W(DATA_W)) u_wr_stage (
    .clk(clk), .rst(rst),
    .in_valid(wr_in_valid), .in_data(host_in_data), .in_ready(wr_in_ready),
    .out_valid(wr_valid), .out_data(wr_data), .out_ready(wr_ready)
  );

  stream_stage #(.W(DATA_W)) u_rd_stage (
    .clk(clk), .rst(rst),
    .in_valid(rd_in_valid), .in_data(bus_rd_data), .in_ready(rd_in_ready),
    .out_valid(host_out_valid), .out_data(host_out_data), .out_ready(host_out_ready)
  );
endmodule

// File: rtl/cmd_bus_bridge_chk.sv
module cmd_bus_bridge_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] host_in_data,
  input logic              host_in_valid,
  input logic              host_in_ready,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_read,
  input logic [ADDR_W-1:0] req_dev,
  input logic [DATA_W-1:0] req_reg,
  input logic [CNT_W-1:0]  req_count,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [DATA_W-1:0] bus_rd_data,
  input logic              bus_rd_valid,
  input logic              bus_rd_ready,
  input logic [DATA_W-1:0] host_out_data,
  input logic              host_out_valid,
  input logic              host_out_ready,
  input logic              txn_done,
  input logic              err_addr
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (host_in_ready && !req_valid && !wr_valid && !host_out_valid && !err_addr));

  // R6
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    err_addr |=> !err_addr);

  // R6
  err_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    err_addr |-> !req_valid);

  // R8
  req_blocks_in_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !host_in_ready);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=>
      (req_valid && $stable(req_read) && $stable(req_dev) && $stable(req_reg) && $stable(req_count)));

  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (host_out_valid && !host_out_ready) |=> (host_out_valid && $stable(host_out_data)));

  // R7
  rd_closed_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid || wr_valid) |-> !bus_rd_ready);
endmodule

bind cmd_bus_bridge cmd_bus_bridge_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_cmd_bus_bridge.sv
module tb_cmd_bus_bridge;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] host_in_data = '0;
  logic host_in_valid = 1'b0, host_in_ready;
  logic req_valid, req_ready = 1'b0, req_read;
  logic [6:0] req_dev;
  logic [7:0] req_reg, req_count;
  logic [7:0] wr_data;
  logic wr_valid, wr_ready = 1'b0;
  logic [7:0] bus_rd_data = '0;
  logic bus_rd_valid = 1'b0, bus_rd_ready;
  logic [7:0] host_out_data;
  logic host_out_valid, host_out_ready = 1'b0;
  logic txn_done = 1'b0, err_addr;

  always #2 clk = ~clk;

  cmd_bus_bridge dut (.*);

  int checks = 0, fails = 0;
  logic [7:0] in_q[$], exp_wr[$], exp_out[$];
  logic [23:0] exp_req[$];
  int exp_err = 0, exp_req_total = 0, req_seen = 0, err_seen = 0;
  bit bm_busy = 0, bm_rd = 0, done_pend = 0;
  int bm_left = 0, cyc = 0;
  bit p_req_stall = 0, p_wr_stall = 0, p_out_stall = 0;
  logic [23:0] p_req;
  logic [7:0] p_wr, p_out;

  task automatic check(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // kind 0 stray letter, 1 read, 2 write
  task automatic gen_cmd(int kind, logic [7:0] dev, logic [7:0] rg, logic [7:0] cnt);
    if (kind == 0) begin
      logic [7:0] b;
      b = 8'($urandom);
      if (b == 8'h72 || b == 8'h77) b = 8'h00;
      in_q.push_back(b);
      return;
    end
    in_q.push_back(kind == 1 ? 8'h72 : 8'h77);
    in_q.push_back(dev);
    in_q.push_back(rg);
    in_q.push_back(cnt);
    if (dev > 8'h7F) exp_err++;
    if (kind == 2) begin
      for (int i = 0; i < int'(cnt); i++) begin
        logic [7:0] v;
        v = 8'($urandom);
        in_q.push_back(v);
        if (dev <= 8'h7F) exp_wr.push_back(v);
      end
    end
    if (dev <= 8'h7F && cnt != 0) begin
      exp_req.push_back({kind == 1, dev[6:0], rg, cnt});
      exp_req_total++;
    end
  endtask

  task automatic step();
    logic [23:0] cur;
    @(negedge clk);
    cyc++;
    host_in_valid  = (in_q.size() > 0) && ($urandom % 4 != 0);
    host_in_data   = (in_q.size() > 0) ? in_q[0] : 8'h00;
    req_ready      = ($urandom % 3 != 0);
    wr_ready       = ($urandom % 3 != 0);
    host_out_ready = ($urandom % 3 != 0);
    txn_done       = done_pend;
    done_pend      = 0;
    bus_rd_valid   = bm_busy && bm_rd && (bm_left > 0) && ($urandom % 3 != 0);
    bus_rd_data    = 8'($urandom);
    #1;
    cur = {req_read, req_dev, req_reg, req_count};
    if (p_req_stall) check(req_valid && cur == p_req, "R9 request held", int'(cur), int'(p_req));
    if (p_wr_stall)  check(wr_valid && wr_data == p_wr, "R10 write held", wr_data, p_wr);
    if (p_out_stall) check(host_out_valid && host_out_data == p_out, "R10 out held", host_out_data, p_out);
    p_req_stall = req_valid && !req_ready;
    p_wr_stall  = wr_valid && !wr_ready;
    p_out_stall = host_out_valid && !host_out_ready;
    p_req = cur; p_wr = wr_data; p_out = host_out_data;

    if (host_in_valid && host_in_ready) void'(in_q.pop_front());
    if (req_valid) check(!host_in_ready, "R8 input closed", host_in_ready, 0);
    if (req_valid && req_ready) begin
      req_seen++;
      if (exp_req.size() == 0) check(0, "R2 R5 R6 unexpected request", int'(cur), 0);
      else begin
        logic [23:0] e;
        e = exp_req.pop_front();
        check(cur == e, e[23] ? "R3 read request" : "R4 write request", int'(cur), int'(e));
      end
      check(!bm_busy, "R8 overlap", bm_busy, 0);
      bm_busy = 1; bm_rd = req_read; bm_left = int'(req_count);
    end
    if (wr_valid && wr_ready) begin
      if (exp_wr.size() == 0) check(0, "R4 R6 extra write byte", wr_data, 0);
      else begin
        logic [7:0] e;
        e = exp_wr.pop_front();
        check(wr_data == e, "R4 write payload", wr_data, e);
      end
      bm_left--;
      if (bm_left <= 0) begin bm_busy = 0; done_pend = 1; end
    end
    if (bus_rd_valid && bus_rd_ready) begin
      exp_out.push_back(bus_rd_data);
      bm_left--;
      if (bm_left <= 0) begin bm_busy = 0; done_pend = 1; end
    end
    if (host_out_valid && host_out_ready) begin
      if (exp_out.size() == 0) check(0, "R7 extra read byte", host_out_data, 0);
      else begin
        logic [7:0] e;
        e = exp_out.pop_front();
        check(host_out_data == e, "R7 read data", host_out_data, e);
      end
    end
    if (err_addr) begin
      err_seen++;
      check(exp_err > 0, "R6 unexpected error", err_seen, exp_err);
      if (exp_err > 0) exp_err--;
    end
  endtask

  task automatic drain();
    int quiet = 0;
    while (quiet < 30 && cyc < 190000) begin
      step();
      if (in_q.size() == 0 && !bm_busy && exp_out.size() == 0 && !host_out_valid && !wr_valid) quiet++;
      else quiet = 0;
    end
    if (cyc >= 190000) check(0, "R8 watchdog expired", cyc, 190000);
  endtask

  initial begin
    process::self().srandom(32'd4711);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(host_in_ready && !req_valid && !wr_valid && !host_out_valid && !err_addr,
          "R1 reset state", {host_in_ready, req_valid, wr_valid, host_out_valid, err_addr}, 5'b10000);

    // directed corner cases
    gen_cmd(0, 0, 0, 0);                 // R2 stray letter
    in_q.push_back(8'h41);               // R2 another stray letter
    gen_cmd(1, 8'h12, 8'h05, 8'd1);      // R3
    gen_cmd(2, 8'h7F, 8'h10, 8'd0);      // R5 write count zero, no payload
    gen_cmd(1, 8'h03, 8'h20, 8'd0);      // R5 read count zero
    gen_cmd(1, 8'h80, 8'h01, 8'd2);      // R6 bad read
    gen_cmd(2, 8'hFF, 8'h02, 8'd3);      // R6 bad write, payload skipped
    gen_cmd(2, 8'h00, 8'h33, 8'd4);      // R4
    gen_cmd(1, 8'h57, 8'hFF, 8'd5);      // R7
    drain();
    check(req_seen == exp_req_total, "R2 R5 request count", req_seen, exp_req_total);
    check(err_seen == 2, "R6 error count", err_seen, 2);
    check(exp_req.size() == 0, "R3 pending requests", exp_req.size(), 0);

    // random traffic
    for (int n = 0; n < 80; n++) begin
      int kind;
      logic [7:0] dev;
      kind = $urandom % 7;
      kind = (kind == 0) ? 0 : (kind < 4 ? 1 : 2);
      dev  = ($urandom % 8 == 0) ? (8'h80 | 8'($urandom)) : (8'($urandom) & 8'h7F);
      gen_cmd(kind, dev, 8'($urandom), 8'($urandom % 7));
    end
    drain();
    check(req_seen == exp_req_total, "R3 R4 total requests", req_seen, exp_req_total);
    check(exp_wr.size() == 0, "R4 payload fully sent", exp_wr.size(), 0);
    check(exp_out.size() == 0, "R7 read bytes delivered", exp_out.size(), 0);
    check(exp_err == 0, "R6 all errors flagged", exp_err, 0);
    check(host_in_ready && !req_valid, "R8 idle again", host_in_ready, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule